// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Each clock it sees a set of event groups, each carrying eight sub-event lines, together with the current privilege level. A configuration word chooses one group by an 8-bit event code and picks sub-events inside it with an 8-bit unit mask. The per-cycle event number is the population count of the masked lines of the chosen group. That number then passes through a threshold compare, an optional inversion of that compare, an optional rising-edge filter, and a privilege gate before it reaches a 40-bit counter.

Software writes the configuration, reads and writes the counter and reads an overflow status bit. When the counter wraps past all-ones it raises a one-cycle interrupt pulse and sets the sticky status bit. The register port is a plain single-cycle write strobe with a combinational read mux.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the configuration, counter and status all read as zero and ovfIrq is low.
- R2: Group i answers to event code BASE_CODE+i (default 0x40). The per-cycle number is the count of ones in (its 8 sub-event lines AND the unit mask). A code outside the range gives zero.
- R3: With threshold 0 and edge clear, the counter adds the per-cycle number each cycle, and the invert bit has no effect.
- R4: With a nonzero threshold, invert clear and edge clear, the counter adds one in each cycle whose number is at least the threshold, and zero otherwise.
- R5: With a nonzero threshold and invert set, the counter adds one in each cycle whose number is strictly below the threshold.
- R6: With edge set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. The condition is "number nonzero" when the threshold is 0.
- R7: The kernel enable (config bit 26) counts at privilege level 0 and the user enable (bit 27) counts at levels 1 to 3. Cycles at a level that is not enabled add nothing and count as a false condition.
- R8: When both the kernel and the user enable are clear, every privilege level counts.
- R9: The counter moves only while the enable (bit 28) is set. The stored edge condition is cleared in any cycle where the block is disabled or the configuration is written.
- R10: A write to the counter (address 1) loads regWdata[39:0] and overrides any increment in that cycle.
- R11: An increment that carries out of bit 39 wraps the counter and gives a one-cycle ovfIrq pulse on the next cycle, and the status bit (address 2, bit 0) becomes 1.
- R12: Writing address 2 with bit 0 set clears the status bit. An overflow in the same cycle wins.
- R13: Address 0 reads back the configuration: code [7:0], mask [15:8], threshold [23:16], invert [24], edge [25], kernel [26], user [27], enable [28]. Address 1 reads the counter, address 2 reads the status bit and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| subEvt | input | NUM_SRC*8 | Sub-event lines, 8 per group, group i at [8i+7:8i] |
| privLvl | input | 2 | Current privilege level, 0 is kernel |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Write address |
| regWdata | input | 64 | Write data |
| regRaddr | input | 2 | Read address |
| regRdata | output | 64 | Read data, combinational |
| ovfIrq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
A wrong edge memory, privilege gate or threshold compare shows up as a counter value that differs from the reference by the next clock, because the bench reads the counter back every cycle. A stale or wrongly cleared status bit appears at the next status read, and a wrong carry appears as a missing or doubled ovfIrq pulse in the cycle after the wrap. Near-wrap loads and reconfiguration while the condition is held true are driven on purpose, so that write priority and edge clearing are each checked within one cycle of the event.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int MASK_W = 8;
  localparam int CODE_W = 8;
  localparam int THR_W  = 8;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic              en;
    logic              usrEn;
    logic              krnEn;
    logic              edgeMode;
    logic              invert;
    logic [THR_W-1:0]  thresh;
    logic [MASK_W-1:0] umask;
    logic [CODE_W-1:0] code;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic cfgWr;
    logic cntWr;
    logic stsClr;
  } strobe_t;

  typedef enum logic [1:0] {
    ADDR_CFG = 2'd0,
    ADDR_CNT = 2'd1,
    ADDR_STS = 2'd2,
    ADDR_NUL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/qec_ctrl.sv
module qec_ctrl
  import qec_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [1:0]        regRaddr,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic              stickyOvf,
  output cfg_t              cfgQ,
  output strobe_t           stb,
  output logic [DATA_W-1:0] regRdata
);
  always_comb begin
    stb.cfgWr  = regWe && (regAddr == ADDR_CFG);
    stb.cntWr  = regWe && (regAddr == ADDR_CNT);
    stb.stsClr = regWe && (regAddr == ADDR_STS) && regWdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else if (stb.cfgWr) cfgQ <= cfg_t'(regWdata[CFG_W-1:0]);
  end

  always_comb begin
    regRdata = '0;
    unique case (reg_addr_e'(regRaddr))
      ADDR_CFG: regRdata[CFG_W-1:0] = cfgQ;
      ADDR_CNT: regRdata[CNT_W-1:0] = cntQ;
      ADDR_STS: regRdata[0] = stickyOvf;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/qec_datapath.sv
module qec_datapath
  import qec_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int CNT_W     = 40,
  parameter int BASE_CODE = 'h40
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfg_t                      cfgQ,
  input  strobe_t                   stb,
  input  logic [NUM_SRC*MASK_W-1:0] subEvt,
  input  logic [1:0]                privLvl,
  input  logic [CNT_W-1:0]          cntWdata,
  output logic [CNT_W-1:0]          cntQ,
  output logic                      ovfPulse,
  output logic                      stickyOvf
);
  localparam int NW = $clog2(MASK_W + 1);

  function automatic logic [NW-1:0] popCount(input logic [MASK_W-1:0] v);
    logic [NW-1:0] acc;
    acc = '0;
    for (int b = 0; b < MASK_W; b++) acc = acc + NW'(v[b]);
    return acc;
  endfunction

  logic [NUM_SRC-1:0] grpHit;
  logic [NW-1:0]      grpNum [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_grp
    localparam logic [CODE_W-1:0] GCODE = CODE_W'(BASE_CODE + i);
    assign grpHit[i] = (cfgQ.code == GCODE);
    assign grpNum[i] = popCount(subEvt[i*MASK_W +: MASK_W] & cfgQ.umask);
  end

  logic [NW-1:0] evtNum;
  always_comb begin
    evtNum = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grpHit[i]) evtNum = evtNum | grpNum[i];
  end

  logic             privOk, thrZero, cond, qualCond, prevQual;
  logic [THR_W-1:0] numExt;
  logic [NW-1:0]    incAmt;
  logic [CNT_W:0]   sum;

  always_comb begin
    privOk = (!cfgQ.krnEn && !cfgQ.usrEn) ||
             ((privLvl == 2'd0) ? cfgQ.krnEn : cfgQ.usrEn);
    numExt  = THR_W'(evtNum);
    thrZero = (cfgQ.thresh == '0);
    if (thrZero)           cond = (evtNum != '0);
    else if (cfgQ.invert)  cond = (numExt < cfgQ.thresh);
    else                   cond = (numExt >= cfgQ.thresh);
    qualCond = privOk && cond;
    if (!privOk)            incAmt = '0;
    else if (cfgQ.edgeMode) incAmt = NW'(qualCond && !prevQual);
    else if (thrZero)       incAmt = evtNum;
    else                    incAmt = NW'(cond);
    sum = {1'b0, cntQ} + (CNT_W+1)'(incAmt);
  end

  logic wrapNow;
  assign wrapNow = cfgQ.en && !stb.cntWr && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      ovfPulse  <= 1'b0;
      stickyOvf <= 1'b0;
      prevQual  <= 1'b0;
    end else begin
      if (stb.cntWr)    cntQ <= cntWdata;
      else if (cfgQ.en) cntQ <= sum[CNT_W-1:0];
      ovfPulse <= wrapNow;
      if (wrapNow)         stickyOvf <= 1'b1;
      else if (stb.stsClr) stickyOvf <= 1'b0;
      prevQual <= (stb.cfgWr || !cfgQ.en) ? 1'b0 : qualCond;
    end
  end
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int CNT_W     = 40,
  parameter int BASE_CODE = 'h40
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC*MASK_W-1:0] subEvt,
  input  logic [1:0]                privLvl,
  input  logic                      regWe,
  input  logic [1:0]                regAddr,
  input  logic [DATA_W-1:0]         regWdata,
  input  logic [1:0]                regRaddr,
  output logic [DATA_W-1:0]         regRdata,
  output logic                      ovfIrq
);
  cfg_t             cfgQ;
  strobe_t          stb;
  logic [CNT_W-1:0] cntQ;
  logic             stickyOvf;

  qec_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRaddr(regRaddr), .cntQ(cntQ),
    .stickyOvf(stickyOvf), .cfgQ(cfgQ), .stb(stb), .regRdata(regRdata)
  );

  qec_datapath #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .BASE_CODE(BASE_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .stb(stb), .subEvt(subEvt),
    .privLvl(privLvl), .cntWdata(regWdata[CNT_W-1:0]), .cntQ(cntQ),
    .ovfPulse(ovfIrq), .stickyOvf(stickyOvf)
  );
endmodule

// File: rtl/qec_checker.sv
module qec_checker
  import qec_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [1:0]        privLvl,
  input cfg_t              cfgQ,
  input logic [CNT_W-1:0]  cntQ,
  input logic              stickyOvf,
  input logic              ovfIrq
);
  logic cntWrite, stsWrite;
  assign cntWrite = regWe && (regAddr == 2'd1);
  assign stsWrite = regWe && (regAddr == 2'd2) && regWdata[0];

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cfgQ.en && !cntWrite) |-> (cntQ == $past(cntQ)));

  // R7
  kernel_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgQ.en && cfgQ.krnEn && !cfgQ.usrEn && privLvl != 2'd0 && !cntWrite)
      |-> (cntQ == $past(cntQ)));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWrite) |-> (cntQ == $past(regWdata[CNT_W-1:0])));

  // R11
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |=> !ovfIrq);

  // R11
  pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> stickyOvf);

  // R12
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stsWrite) && !ovfIrq) |-> !stickyOvf);

  // R2
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cntWrite) |-> ((cntQ - $past(cntQ)) <= CNT_W'(MASK_W)));
endmodule

bind qual_event_counter qec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .privLvl(privLvl), .cfgQ(cfgQ), .cntQ(cntQ),
  .stickyOvf(stickyOvf), .ovfIrq(ovfIrq)
);

// File: tb/tb_qual_event_counter.sv
module tb_qual_event_counter;
  localparam int NSRC = 4;
  localparam int BASE = 'h40;
  localparam longint unsigned CMASK = (64'd1 << 40) - 1;

  logic clk = 0, rstN = 0;
  logic [NSRC*8-1:0] subEvt = '0;
  logic [1:0] privLvl = '0, regAddr = '0, regRaddr = 2'd1;
  logic regWe = 0;
  logic [63:0] regWdata = '0, regRdata;
  logic ovfIrq;

  qual_event_counter #(.NUM_SRC(NSRC), .CNT_W(40), .BASE_CODE(BASE)) dut (
    .clk(clk), .rstN(rstN), .subEvt(subEvt), .privLvl(privLvl), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRaddr(regRaddr),
    .regRdata(regRdata), .ovfIrq(ovfIrq));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  string curTag = "R1";
  bit finished = 0;

  longint unsigned mCfg = 0, mCnt = 0;
  bit mSticky = 0, mPrev = 0, mIrq = 0;

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: evaluate one clock with the inputs currently driven
  task automatic modelTick();
    int code, mask, thr, n, grp, inc;
    bit inv, edg, krn, usr, en, privOk, cond, qual;
    longint unsigned nxt;
    code = int'(mCfg & 64'hFF);      mask = int'((mCfg >> 8) & 64'hFF);
    thr  = int'((mCfg >> 16) & 64'hFF);
    inv = mCfg[24]; edg = mCfg[25]; krn = mCfg[26]; usr = mCfg[27]; en = mCfg[28];
    n = 0;
    if (code >= BASE && code < BASE + NSRC) begin
      grp = code - BASE;
      n = $countones(subEvt[grp*8 +: 8] & 8'(mask));
    end
    if (!krn && !usr) privOk = 1;
    else if (privLvl == 0) privOk = krn;
    else privOk = usr;
    if (thr == 0) cond = (n != 0);
    else if (inv) cond = (n < thr);
    else cond = (n >= thr);
    qual = privOk && cond;
    if (!privOk) inc = 0;
    else if (edg) inc = (qual && !mPrev) ? 1 : 0;
    else if (thr == 0) inc = n;
    else inc = cond ? 1 : 0;
    mIrq = 0;
    if (regWe && regAddr == 1) mCnt = regWdata & CMASK;
    else if (en) begin
      nxt = mCnt + longint'(inc);
      if (nxt > CMASK) mIrq = 1;
      mCnt = nxt & CMASK;
    end
    if (mIrq) mSticky = 1;
    else if (regWe && regAddr == 2 && regWdata[0]) mSticky = 0;
    mPrev = ((regWe && regAddr == 0) || !en) ? 0 : qual;
    if (regWe && regAddr == 0) mCfg = regWdata & 64'h1FFF_FFFF;
  endtask

  function automatic longint unsigned expRead(input logic [1:0] a);
    case (a)
      2'd0: return mCfg;
      2'd1: return mCnt;
      2'd2: return {63'd0, mSticky};
      default: return 0;
    endcase
  endfunction

  // inputs are set before this call, at the falling edge
  task automatic step();
    @(posedge clk);
    modelTick();
    #1;
    check(regRdata == expRead(regRaddr), curTag, regRdata, expRead(regRaddr));
    check(ovfIrq == mIrq, {curTag, " irq"}, ovfIrq, mIrq);
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic wr(input logic [1:0] a, input longint unsigned d);
    regWe = 1; regAddr = a; regWdata = d;
    step();
  endtask

  task automatic runRand(input int cycles, input int privMode);
    for (int k = 0; k < cycles; k++) begin
      subEvt = $urandom;
      privLvl = (privMode < 0) ? 2'($urandom) : 2'(privMode);
      step();
    end
  endtask

  function automatic longint unsigned mkCfg(input int code, input int mask,
      input int thr, input bit inv, input bit edg, input bit krn, input bit usr,
      input bit en);
    return {35'd0, en, usr, krn, edg, inv, 8'(thr), 8'(mask), 8'(code)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    curTag = "R1";
    for (int a = 0; a < 4; a++) begin
      regRaddr = 2'(a); #1;
      check(regRdata == 0, "R1 reset read", regRdata, 0);
    end
    check(ovfIrq == 0, "R1 irq", ovfIrq, 0);
    regRaddr = 2'd1;
    step();

    // R13 register readback
    curTag = "R13";
    wr(0, mkCfg(BASE + 2, 8'hA5, 3, 1, 0, 1, 0, 0));
    regRaddr = 0; step();
    regRaddr = 3; step();
    regRaddr = 1;

    // R2 / R3 raw counting, mask, invert ignored at threshold 0
    curTag = "R2";
    wr(0, mkCfg(BASE + 1, 8'h3C, 0, 0, 0, 0, 0, 1)); runRand(60, -1);
    wr(0, mkCfg(BASE + 3, 8'hFF, 0, 0, 0, 0, 0, 1)); runRand(60, -1);
    wr(0, mkCfg(BASE + NSRC, 8'hFF, 0, 0, 0, 0, 0, 1)); runRand(40, -1);
    wr(0, mkCfg(BASE - 1, 8'hFF, 0, 0, 0, 0, 0, 1)); runRand(20, -1);
    curTag = "R3";
    wr(0, mkCfg(BASE, 8'hF0, 0, 1, 0, 0, 0, 1)); runRand(60, -1);

    // R4 threshold, R5 inverted threshold
    curTag = "R4";
    wr(0, mkCfg(BASE, 8'hFF, 4, 0, 0, 0, 0, 1)); runRand(80, -1);
    wr(0, mkCfg(BASE + 2, 8'h0F, 8, 0, 0, 0, 0, 1)); runRand(40, -1);
    curTag = "R5";
    wr(0, mkCfg(BASE, 8'hFF, 4, 1, 0, 0, 0, 1)); runRand(80, -1);

    // R6 edge, held condition then random
    curTag = "R6";
    wr(0, mkCfg(BASE, 8'hFF, 2, 0, 1, 0, 0, 1));
    subEvt = 32'h0000_0007;
    for (int k = 0; k < 6; k++) step();
    subEvt = 0; step(); subEvt = 32'h0000_0003; step(); step();
    runRand(60, -1);
    wr(0, mkCfg(BASE + 1, 8'hFF, 0, 0, 1, 0, 0, 1)); runRand(60, -1);

    // R7 privilege enables, R8 none set
    curTag = "R7";
    wr(0, mkCfg(BASE, 8'hFF, 0, 0, 0, 1, 0, 1)); runRand(40, -1); runRand(10, 2);
    wr(0, mkCfg(BASE, 8'hFF, 0, 0, 0, 0, 1, 1)); runRand(40, -1); runRand(10, 0);
    wr(0, mkCfg(BASE, 8'hFF, 3, 1, 1, 1, 0, 1)); runRand(40, -1);
    curTag = "R8";
    wr(0, mkCfg(BASE, 8'hFF, 0, 0, 0, 0, 0, 1));
    for (int p = 0; p < 4; p++) runRand(10, p);

    // R9 enable gate and edge memory clear on reconfig and disable
    curTag = "R9";
    wr(0, mkCfg(BASE, 8'hFF, 0, 0, 0, 0, 0, 0)); runRand(20, -1);
    wr(0, mkCfg(BASE, 8'hFF, 1, 0, 1, 0, 0, 1));
    subEvt = 32'hFF;
    step(); step();
    wr(0, mkCfg(BASE, 8'hFF, 1, 0, 1, 0, 0, 1)); step(); step();
    wr(0, mkCfg(BASE, 8'hFF, 1, 0, 1, 0, 0, 0)); step();
    wr(0, mkCfg(BASE, 8'hFF, 1, 0, 1, 0, 0, 1)); step(); step();

    // R10 counter write overrides increment
    curTag = "R10";
    wr(0, mkCfg(BASE, 8'hFF, 0, 0, 0, 0, 0, 1));
    subEvt = 32'hFF;
    wr(1, 64'h12_3456_789A); step();
    check(regRdata == 64'h12_3456_789A + 8, "R10 write then count", regRdata,
          64'h12_3456_789A + 8);

    // R11 overflow pulse and sticky, R12 clear
    curTag = "R11";
    wr(1, CMASK - 2); step(); step();
    regRaddr = 2; step(); regRaddr = 1;
    wr(1, CMASK); subEvt = 0; step(); step();
    curTag = "R12";
    regRaddr = 2;
    wr(2, 64'h0); step();
    wr(2, 64'h1); step();
    check(regRdata == 0, "R12 cleared", regRdata, 0);
    subEvt = 32'hFF;
    wr(1, CMASK - 1);
    wr(2, 64'h1);
    check(regRdata == 1, "R12 set wins", regRdata, 1);
    regRaddr = 1;
    curTag = "R11";
    runRand(40, -1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule